// File: doc/BRIEF.md
# Carry-Lookahead Adder/Subtractor

This block is a purely combinational 32-bit two's-complement adder/subtractor. It uses a two-level carry-lookahead network, so no carry ripples through the word. Each operand is split into four 8-bit slices. Inside a slice, every carry comes from a flat AND-OR expression over per-bit generate and propagate terms. A second lookahead network takes the generate and propagate summary of each slice and produces the carry into every slice, and the carry out of the word.

The mode input selects the operation. When it is low, the block adds the operands. When it is high, it inverts every bit of the second operand and puts a carry-in of one into the lowest bit, which gives the two's-complement difference. Along with the sum, the block reports the carry out of the top bit and a signed-overflow flag. The flag is the XOR of the carry into the top bit and the carry out of it. The block has no clock and holds no state; a surrounding datapath registers the results if it needs to.

Top module: `addsub_cla_top`

## Requirements
- R1: With `mode` = 0, `sum` equals the low 32 bits of `x + y`.
- R2: With `mode` = 1, `sum` equals the low 32 bits of `x - y`, which is `x + ~y + 1`.
- R3: With `mode` = 0, `carry_out` equals bit 32 of the unsigned 33-bit result of `x + y`.
- R4: With `mode` = 1, `carry_out` equals bit 32 of `x + ~y + 1`. A 1 means no borrow (x >= y as unsigned values) and a 0 means a borrow.
- R5: `overflow` is 1 exactly when the signed result does not fit in 32 bits. In that case the two effective operands (`x` and `y`, or `x` and `~y` when subtracting) have the same sign bit, and `sum` bit 31 differs from it.
- R6: The carry into each 8-bit slice (bit positions 0, 8, 16 and 24) equals the carry that arises from the full addition of all lower bits, including the injected carry-in. A carry therefore crosses one or more slice boundaries correctly.
- R7: The outputs depend only on the present inputs. They follow an input change without any clock edge, and they are independent of any reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 32 | First operand |
| y | input | 32 | Second operand (subtrahend when `mode` = 1) |
| mode | input | 1 | 0 = add, 1 = subtract |
| sum | output | 32 | Sum or difference |
| carry_out | output | 1 | Carry out of bit 31 (in subtract mode, 1 = no borrow) |
| overflow | output | 1 | Signed two's-complement overflow |

## Verification
The checker compares the sum, carry-out and overflow against an independent wide arithmetic model for every input combination the block sees. It also checks that the slice carries from the second lookahead level agree with a partial-word addition at each slice boundary. The bench has a table of corner operands: zero, the maximum and minimum signed values, all ones, and carries that cross one or several slice boundaries. It runs this table and then random operands in both modes. It also shows, by changing inputs between clock edges and during reset, that the outputs follow the inputs with no dependence on the clock.

// File: rtl/addsub_cla_pkg.sv
// Package: shared constants and types for the lookahead adder/subtractor.
// Assumes: the word width is a whole multiple of the slice width.
package addsub_cla_pkg;

    localparam int WORD_W  = 32;
    localparam int SLICE_W = 8;

    // Operation encoding carried on the mode input.
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_mode_e;

endpackage

// File: rtl/cla_lookahead.sv
// Module: cla_lookahead
// What:   Flat carry-lookahead network. From N generate/propagate pairs and a
//         carry-in it forms the carry into each position, plus the summary
//         generate and propagate of the whole span.
// Assumes: N is small enough that the two-level AND-OR terms stay practical
//          (used here with N = 8 and N = 4).
module cla_lookahead #(
    parameter int N = 8
) (
    input  logic [N-1:0] gen,
    input  logic [N-1:0] prop,
    input  logic         cin,
    output logic [N-1:0] carry_in,
    output logic         span_gen,
    output logic         span_prop
);

    // Carry into position k: OR of every generate below k, each ANDed with
    // the propagates above it, plus cin ANDed with all propagates below k.
    always_comb begin
        logic acc;
        logic prod;
        carry_in[0] = cin;
        for (int k = 1; k < N; k++) begin
            prod = cin;
            for (int j = 0; j < k; j++) prod = prod & prop[j];
            acc = prod;
            for (int j = 0; j < k; j++) begin
                prod = gen[j];
                for (int m = j + 1; m < k; m++) prod = prod & prop[m];
                acc = acc | prod;
            end
            carry_in[k] = acc;
        end
    end

    // Summary generate: some position generates and every position above
    // it propagates.
    always_comb begin
        logic acc;
        logic prod;
        acc = 1'b0;
        for (int j = 0; j < N; j++) begin
            prod = gen[j];
            for (int m = j + 1; m < N; m++) prod = prod & prop[m];
            acc = acc | prod;
        end
        span_gen = acc;
    end

    // Summary propagate: every position propagates.
    always_comb begin
        logic acc;
        acc = 1'b1;
        for (int j = 0; j < N; j++) acc = acc & prop[j];
        span_prop = acc;
    end

endmodule

// File: rtl/cla_slice.sv
// Module: cla_slice
// What:   One lookahead slice. Forms per-bit generate (a AND b) and propagate
//         (a OR b) and resolves the carry into every bit of the slice from
//         the slice carry-in.
// Assumes: b has already been conditioned for subtraction by the caller.
module cla_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] bit_carry,
    output logic         slice_gen,
    output logic         slice_prop
);

    logic [W-1:0] gen;
    logic [W-1:0] prop;

    // Per-bit generate and propagate terms.
    always_comb begin
        gen  = a & b;
        prop = a | b;
    end

    cla_lookahead #(.N(W)) u_la (
        .gen       (gen),
        .prop      (prop),
        .cin       (cin),
        .carry_in  (bit_carry),
        .span_gen  (slice_gen),
        .span_prop (slice_prop)
    );

endmodule

// File: rtl/addsub_cla_top.sv
// Module: addsub_cla_top
// What:   Combinational two's-complement adder/subtractor with two-level
//         carry lookahead: flat lookahead inside each slice, and a second
//         lookahead over the slice summaries that gives the carry into each
//         slice and the word carry-out. Signed overflow is the XOR of the
//         carries into and out of the top bit.
// Assumes: no clock or reset; the parent registers the outputs if needed.
module addsub_cla_top
    import addsub_cla_pkg::*;
#(
    parameter int WIDTH   = WORD_W,
    parameter int SLICE   = SLICE_W
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             mode,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             overflow
);

    localparam int NSLICE = WIDTH / SLICE;

    logic [WIDTH-1:0]  y_eff;
    logic [WIDTH-1:0]  c_bits;
    logic [NSLICE-1:0] slc_gen;
    logic [NSLICE-1:0] slc_prop;
    logic [NSLICE-1:0] grp_cin;
    logic              word_gen;
    logic              word_prop;

    // Condition the second operand: XOR with the mode bit inverts it when subtracting.
    always_comb y_eff = y ^ {WIDTH{mode == OP_SUB}};

    // First level: one lookahead slice per SLICE-bit group.
    for (genvar gi = 0; gi < NSLICE; gi++) begin : g_slice
        cla_slice #(.W(SLICE)) u_slice (
            .a          (x[gi*SLICE +: SLICE]),
            .b          (y_eff[gi*SLICE +: SLICE]),
            .cin        (grp_cin[gi]),
            .bit_carry  (c_bits[gi*SLICE +: SLICE]),
            .slice_gen  (slc_gen[gi]),
            .slice_prop (slc_prop[gi])
        );
    end

    // Second level: carries between slices; the mode bit is the carry-in.
    cla_lookahead #(.N(NSLICE)) u_grp_la (
        .gen       (slc_gen),
        .prop      (slc_prop),
        .cin       (mode),
        .carry_in  (grp_cin),
        .span_gen  (word_gen),
        .span_prop (word_prop)
    );

    // Result bits, carry out of the word, and signed overflow.
    always_comb begin
        sum       = x ^ y_eff ^ c_bits;
        carry_out = word_gen | (word_prop & mode);
        overflow  = c_bits[WIDTH-1] ^ carry_out;
    end

endmodule

// File: rtl/addsub_cla_chk.sv
// Module: addsub_cla_chk
// What:   Checker bound to addsub_cla_top. Compares the outputs and the
//         inter-slice carries against a wide arithmetic model whenever any
//         input changes.
// Assumes: bound with the same WIDTH/SLICE as the target instance.
module addsub_cla_chk #(
    parameter int WIDTH = 32,
    parameter int SLICE = 8
) (
    input logic [WIDTH-1:0]         x,
    input logic [WIDTH-1:0]         y,
    input logic                     mode,
    input logic [WIDTH-1:0]         sum,
    input logic                     carry_out,
    input logic                     overflow,
    input logic [WIDTH/SLICE-1:0]   grp_cin
);

    localparam int NSLICE = WIDTH / SLICE;
    localparam int WP1    = WIDTH + 1;

    logic [WIDTH-1:0] ye;
    logic [WIDTH:0]   full;

    // Wide reference result for the current inputs.
    always_comb begin
        ye   = y ^ {WIDTH{mode}};
        full = {1'b0, x} + {1'b0, ye} + {{WIDTH{1'b0}}, mode};
    end

    // Output checks against the reference.
    always_comb begin
        AST_SUM_ADD: assert (mode || sum == full[WIDTH-1:0]);            // R1
        AST_SUM_SUB: assert (!mode || sum == (x - y));                   // R2
        AST_CARRY_ADD: assert (mode || carry_out == full[WIDTH]);        // R3
        AST_NO_BORROW: assert (!mode || carry_out == (x >= y));          // R4
        AST_OVERFLOW: assert (overflow ==
            ((x[WIDTH-1] == ye[WIDTH-1]) && (full[WIDTH-1] != x[WIDTH-1]))); // R5
    end

    // Inter-slice carries against a partial-word addition.
    always_comb begin
        logic [WIDTH:0] mask;
        logic [WIDTH:0] part;
        for (int k = 0; k < NSLICE; k++) begin
            mask = (WP1'(1) << (k * SLICE)) - WP1'(1);
            part = ({1'b0, x} & mask) + ({1'b0, ye} & mask) + WP1'(mode);
            AST_SLICE_CARRY: assert (grp_cin[k] == part[k * SLICE]);   // R6
        end
    end

endmodule

bind addsub_cla_top addsub_cla_chk #(.WIDTH(WIDTH), .SLICE(SLICE)) u_chk (
    .x         (x),
    .y         (y),
    .mode      (mode),
    .sum       (sum),
    .carry_out (carry_out),
    .overflow  (overflow),
    .grp_cin   (grp_cin)
);

// File: tb/addsub_cla_top_tb.sv
// Bench for addsub_cla_top: table of corner vectors with expected results,
// then random operands in both modes against an arithmetic model, then
// directed checks for clock and reset independence.
module addsub_cla_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] x = '0;
    logic [31:0] y = '0;
    logic        mode = 1'b0;
    logic [31:0] sum;
    logic        carry_out;
    logic        overflow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    addsub_cla_top u_dut (
        .x(x), .y(y), .mode(mode),
        .sum(sum), .carry_out(carry_out), .overflow(overflow)
    );

    typedef struct packed {
        logic [31:0] vx;
        logic [31:0] vy;
        logic        vm;
        logic [31:0] es;
        logic        ec;
        logic        ev;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
        '{32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'h8000_0000, 1'b0, 1'b1},
        '{32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1, 1'b0},
        '{32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1, 1'b1},
        '{32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 32'h7FFF_FFFF, 1'b1, 1'b1},
        '{32'h1234_5678, 32'h0000_FFFF, 1'b0, 32'h1235_5677, 1'b0, 1'b0},
        '{32'h0000_00FF, 32'h0000_0001, 1'b0, 32'h0000_0100, 1'b0, 1'b0},
        '{32'h00FF_FFFF, 32'h0000_0001, 1'b0, 32'h0100_0000, 1'b0, 1'b0},
        '{32'h0000_0000, 32'h0000_0001, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0},
        '{32'h8000_0000, 32'h0000_0001, 1'b1, 32'h7FFF_FFFF, 1'b1, 1'b1},
        '{32'h0000_0005, 32'h0000_0005, 1'b1, 32'h0000_0000, 1'b1, 1'b0},
        '{32'h0000_0000, 32'h8000_0000, 1'b1, 32'h8000_0000, 1'b0, 1'b1},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b1, 1'b0},
        '{32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'h8000_0000, 1'b0, 1'b1}
    };

    // Compare the three outputs against expected values, one check each.
    task automatic check_out(input string tag, input logic [31:0] es,
                             input logic ec, input logic ev);
        checks++;
        if (sum !== es) begin
            failures++;
            $display("FAIL %s sum: x=%h y=%h mode=%0b actual=%h expected=%h",
                     tag, x, y, mode, sum, es);
        end
        checks++;
        if (carry_out !== ec) begin
            failures++;
            $display("FAIL %s carry_out: x=%h y=%h mode=%0b actual=%0b expected=%0b",
                     tag, x, y, mode, carry_out, ec);
        end
        checks++;
        if (overflow !== ev) begin
            failures++;
            $display("FAIL %s overflow: x=%h y=%h mode=%0b actual=%0b expected=%0b",
                     tag, x, y, mode, overflow, ev);
        end
    endtask

    // Arithmetic model taken from the requirements.
    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic m,
                         output logic [31:0] es, output logic ec, output logic ev);
        logic signed [33:0] sres;
        logic [32:0] ures;
        if (m) begin
            ures = {1'b0, a} + {1'b0, ~b} + 33'd1;
            sres = $signed({{2{a[31]}}, a}) - $signed({{2{b[31]}}, b});
        end else begin
            ures = {1'b0, a} + {1'b0, b};
            sres = $signed({{2{a[31]}}, a}) + $signed({{2{b[31]}}, b});
        end
        es = ures[31:0];
        ec = ures[32];
        ev = (sres > 34'sh0_7FFF_FFFF) || (sres < -34'sh0_8000_0000);
    endtask

    // Drive at the falling edge, sample 1 ns later.
    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic m);
        @(negedge clk);
        x = a; y = b; mode = m;
        #1;
    endtask

    initial begin
        logic [31:0] es;
        logic ec;
        logic ev;

        // R7: outputs during reset follow the inputs (all-zero inputs give zero).
        #1;
        check_out("R7 reset-state", 32'h0, 1'b0, 1'b0);
        x = 32'h0000_0003; y = 32'h0000_0004; mode = 1'b0;
        #1;
        check_out("R7 in-reset add", 32'h0000_0007, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Table walk: R1..R6 corner vectors with hand-derived results.
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].vx, VECS[i].vy, VECS[i].vm);
            check_out(VECS[i].vm ? "R2/R4/R5/R6 table" : "R1/R3/R5/R6 table",
                      VECS[i].es, VECS[i].ec, VECS[i].ev);
        end

        // Random add vectors: R1, R3, R5.
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = $urandom; b = $urandom;
            apply(a, b, 1'b0);
            model(a, b, 1'b0, es, ec, ev);
            check_out("R1/R3/R5 random add", es, ec, ev);
        end

        // Random subtract vectors: R2, R4, R5.
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = $urandom; b = $urandom;
            if (i % 10 == 0) b = a;
            apply(a, b, 1'b1);
            model(a, b, 1'b1, es, ec, ev);
            check_out("R2/R4/R5 random sub", es, ec, ev);
        end

        // R6: carry crossing each slice boundary, add and subtract.
        for (int k = 1; k < 4; k++) begin
            logic [31:0] a;
            a = (32'h1 << (8 * k)) - 32'h1;
            apply(a, 32'h1, 1'b0);
            model(a, 32'h1, 1'b0, es, ec, ev);
            check_out("R6 boundary add", es, ec, ev);
            apply(32'h1 << (8 * k), 32'h1, 1'b1);
            model(32'h1 << (8 * k), 32'h1, 1'b1, es, ec, ev);
            check_out("R6 boundary borrow", es, ec, ev);
        end

        // R7: input changes between clock edges show up without an edge.
        @(posedge clk);
        #0.5;
        x = 32'hFFFF_FFFF; y = 32'h0000_0001; mode = 1'b1;
        #0.5;
        check_out("R7 mid-cycle", 32'hFFFF_FFFE, 1'b1, 1'b0);
        mode = 1'b0;
        #0.5;
        check_out("R7 mode flip", 32'h0000_0000, 1'b1, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule